// File: doc/BRIEF.md
# Codec Channel Test-State Path Controller

This block governs the digital test states of one voice-codec channel. It sits between the downstream (receive) sample stream and the upstream (transmit) sample stream. A nine-bit mode word chooses which test states are active. From that word the block selects the sample that goes to the receive low-pass stage and the sample that goes into the transmit slot. The receive sample can be passed through, replaced by an externally supplied tone, forced to zero, or halved. The transmit slot can carry the filtered or unfiltered upstream sample, one of three loopback sources, or nothing at all.

Fixed priorities settle conflicts between modes. The transmit cutoff overrides every loopback. Interface loopback comes before slot loopback, and slot loopback comes before the digital loopback. The receive cutoff mutes the tone and also disables the digital loopback. The digital loopback can be entered either by its mode bit or by a five-bit impedance code. A host read port returns the most recently captured transmit sample. When the interrupt is armed, each new capture raises an interrupt, and a host read clears it.

Top module: `codec_test_path_ctl`

## Requirements
- R1: After reset the mode word and the impedance code are zero. `rx_out`, `tx_data` and `irq` are 0, and `tx_oe`, `vout_en` and `bfilt_en` are 1.
- R2: With no receive mode set, an `rx_valid` pulse in cycle n puts `rx_in` on `rx_out` and raises `rx_out_vld` for one cycle in cycle n+1.
- R3: With tone enable (mode bit 8) set, `tone_in` replaces `rx_in` as the receive sample.
- R4: With receive cutoff (mode bit 1) set, every receive sample becomes 0, overriding the tone. `bfilt_en` is 0 while the bit is set.
- R5: With receive attenuation (mode bit 3) set, the selected receive sample is arithmetically shifted right by one bit (a 6.02 dB loss). For example, -3 becomes -2 and 0x8000 becomes 0xC000.
- R6: In the normal transmit path, a `tx_valid` pulse captures `tx_hp` (the high-pass/notch output). When HP bypass (mode bit 2) is set, it captures `tx_raw` instead. The captured value appears on `tx_data` with `tx_out_vld` one cycle later.
- R7: With transmit cutoff (mode bit 0) set, `tx_oe` is 0, no `tx_out_vld` is produced, `tx_data` keeps its value and no interrupt is raised. This holds whatever loopback bits are also set.
- R8: With interface loopback (mode bit 5) set, the latest `rx_out` value is captured into the transmit slot. This takes priority over the slot loopback and the digital loopback.
- R9: With slot loopback (mode bit 7) set and no interface loopback, the latest raw `rx_in` sample is captured. This takes priority over the digital loopback.
- R10: With digital loopback (mode bit 6) active, `vout_en` is 0 and the latest `rx_out` value is captured. Receive cutoff disables the digital loopback: `vout_en` returns to 1 and the normal transmit source is used.
- R11: Writing impedance code 5'b10000 activates the digital loopback exactly as mode bit 6 does. Any other code leaves it inactive.
- R12: With interrupt arm (mode bit 4) set, each transmit capture sets `irq` in the next cycle. A `host_rd` pulse reads `host_rdata`, which equals the current `tx_data`, and clears `irq` in the next cycle. A capture in the same cycle as a read keeps `irq` set. With the arm bit clear, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Mode word write strobe |
| cfg_wdata | input | 9 | Mode word: bit0 tx cutoff, 1 rx cutoff, 2 HP bypass, 3 rx attenuation, 4 irq arm, 5 interface loop, 6 digital loop, 7 slot loop, 8 tone |
| imp_wr | input | 1 | Impedance code write strobe |
| imp_wdata | input | 5 | Impedance code |
| rx_valid | input | 1 | Downstream sample strobe |
| rx_in | input | 16 | Downstream sample (two's complement) |
| tone_in | input | 16 | Tone generator sample |
| rx_out_vld | output | 1 | Receive output strobe |
| rx_out | output | 16 | Sample to receive low-pass stage |
| bfilt_en | output | 1 | Enable for the B-filter path |
| vout_en | output | 1 | Analog output driver enable |
| tx_valid | input | 1 | Upstream sample strobe |
| tx_raw | input | 16 | Upstream sample ahead of HP/notch stages |
| tx_hp | input | 16 | Upstream sample after HP/notch stages |
| tx_out_vld | output | 1 | Transmit slot strobe |
| tx_data | output | 16 | Transmit slot sample |
| tx_oe | output | 1 | Transmit data and slot-enable drive enable |
| host_rd | input | 1 | Host read strobe for transmit data |
| host_rdata | output | 16 | Latest captured transmit sample |
| irq | output | 1 | New-transmit-data interrupt |

## Verification
The bench builds the block with its defaults: 16-bit samples, a one-bit attenuation shift, a five-bit impedance code and loop code 16. The 16-bit width lets the bench drive full-scale and negative odd samples, which show whether the attenuation keeps the sign and rounds toward minus infinity. The one-bit shift makes every loopback source distinguishable, because the processed receive value then differs from the raw slot value. Expected samples for both directions go into queues as stimulus is driven, and each output strobe is compared in order.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

   // Mode word; the last member is bit 0.
   typedef struct packed {
      logic tone_on;
      logic slot_loop;
      logic dig_loop;
      logic iface_loop;
      logic irq_arm;
      logic rx_atten;
      logic hp_bypass;
      logic rx_cutoff;
      logic tx_cutoff;
   } test_cfg_t;

   localparam int CFG_W = $bits(test_cfg_t);

   typedef enum logic [2:0] {
      SRC_NORMAL  = 3'd0,
      SRC_DIGLOOP = 3'd1,
      SRC_SLOT    = 3'd2,
      SRC_IFACE   = 3'd3,
      SRC_NONE    = 3'd4
   } tx_src_e;

endpackage

// File: rtl/tmc_mode_reg.sv
module tmc_mode_reg
   import tmc_pkg::*;
#(
   parameter int          IMP_W     = 5,
   parameter int unsigned LOOP_CODE = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [CFG_W-1:0]     cfg_wdata,
   input  logic                 imp_wr,
   input  logic [IMP_W-1:0]     imp_wdata,
   output test_cfg_t            cfg,
   output logic                 dig_loop_act,
   output tx_src_e              tx_src,
   output logic                 vout_en,
   output logic                 bfilt_en
);

   localparam logic [IMP_W-1:0] CODE_V = IMP_W'(LOOP_CODE);

   if (IMP_W < 1 || IMP_W > 16) begin : g_bad_imp_w
      $error("tmc_mode_reg: IMP_W out of range");
   end
   if (LOOP_CODE >= (1 << IMP_W)) begin : g_bad_code
      $error("tmc_mode_reg: LOOP_CODE does not fit IMP_W");
   end

   test_cfg_t        cfg_q;
   logic [IMP_W-1:0] imp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         imp_q <= '0;
      end else begin
         if (cfg_wr) cfg_q <= test_cfg_t'(cfg_wdata);
         if (imp_wr) imp_q <= imp_wdata;
      end
   end

   assign cfg          = cfg_q;
   assign dig_loop_act = (cfg_q.dig_loop || (imp_q == CODE_V)) && !cfg_q.rx_cutoff;
   assign vout_en      = !dig_loop_act;
   assign bfilt_en     = !cfg_q.rx_cutoff;

   // Fixed precedence: cutoff, interface loop, slot loop, digital loop.
   always_comb begin
      if (cfg_q.tx_cutoff)       tx_src = SRC_NONE;
      else if (cfg_q.iface_loop) tx_src = SRC_IFACE;
      else if (cfg_q.slot_loop)  tx_src = SRC_SLOT;
      else if (dig_loop_act)     tx_src = SRC_DIGLOOP;
      else                       tx_src = SRC_NORMAL;
   end

   // R4
   cut_blocks_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.rx_cutoff |-> (vout_en && bfilt_en == 1'b0));

endmodule

// File: rtl/tmc_rx_path.sv
module tmc_rx_path #(
   parameter int W         = 16,
   parameter int ATT_SHIFT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_valid,
   input  logic [W-1:0] rx_in,
   input  logic [W-1:0] tone_in,
   input  logic         tone_on,
   input  logic         rx_cutoff,
   input  logic         rx_atten,
   output logic         rx_out_vld,
   output logic [W-1:0] rx_out,
   output logic [W-1:0] rx_slot
);

   if (W < 8) begin : g_bad_w
      $error("tmc_rx_path: W must be at least 8");
   end
   if (ATT_SHIFT < 0 || ATT_SHIFT >= W) begin : g_bad_shift
      $error("tmc_rx_path: ATT_SHIFT out of range");
   end

   logic signed [W-1:0] pick;
   logic signed [W-1:0] shifted;
   logic        [W-1:0] result;

   always_comb begin
      if (rx_cutoff)    pick = '0;
      else if (tone_on) pick = signed'(tone_in);
      else              pick = signed'(rx_in);
   end

   if (ATT_SHIFT == 0) begin : g_no_att
      assign shifted = pick;
   end else begin : g_att
      assign shifted = pick >>> ATT_SHIFT;
   end

   assign result = rx_atten ? unsigned'(shifted) : unsigned'(pick);

   logic [W-1:0] out_q;
   logic [W-1:0] slot_q;
   logic         vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         slot_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= rx_valid;
         if (rx_valid) begin
            out_q  <= result;
            slot_q <= rx_in;
         end
      end
   end

   assign rx_out     = out_q;
   assign rx_slot    = slot_q;
   assign rx_out_vld = vld_q;

   // R4
   mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_cutoff) |=> (rx_out == '0));

   // R5
   atten_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_atten && !rx_cutoff && !tone_on) |=> (rx_out[W-1] == $past(rx_in[W-1])));

   // R2
   strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> (!rx_out_vld && $stable(rx_out)));

endmodule

// File: rtl/tmc_tx_path.sv
module tmc_tx_path
   import tmc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tx_valid,
   input  logic [W-1:0] tx_raw,
   input  logic [W-1:0] tx_hp,
   input  logic         hp_bypass,
   input  tx_src_e      tx_src,
   input  logic [W-1:0] rx_out,
   input  logic [W-1:0] rx_slot,
   output logic         capture,
   output logic         tx_out_vld,
   output logic [W-1:0] tx_data,
   output logic         tx_oe
);

   logic [W-1:0] pick;

   always_comb begin
      case (tx_src)
         SRC_IFACE:   pick = rx_out;
         SRC_SLOT:    pick = rx_slot;
         SRC_DIGLOOP: pick = rx_out;
         default:     pick = hp_bypass ? tx_raw : tx_hp;
      endcase
   end

   assign capture = tx_valid && (tx_src != SRC_NONE);
   assign tx_oe   = (tx_src != SRC_NONE);

   logic [W-1:0] data_q;
   logic         vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= capture;
         if (capture) data_q <= pick;
      end
   end

   assign tx_data    = data_q;
   assign tx_out_vld = vld_q;

   // R7
   no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_oe) |=> (!tx_out_vld && $stable(tx_data)));

   // R6
   hp_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_src == SRC_NORMAL && hp_bypass) |=> (tx_data == $past(tx_raw)));

   // R9
   slot_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_src == SRC_SLOT) |=> (tx_data == $past(rx_slot)));

endmodule

// File: rtl/tmc_host_irq.sv
module tmc_host_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_arm,
   input  logic capture,
   input  logic host_rd,
   output logic irq
);

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (!irq_arm) irq_q <= 1'b0;
      else if (capture)  irq_q <= 1'b1;
      else if (host_rd)  irq_q <= 1'b0;
   end

   assign irq = irq_q;

   // R12
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_arm && capture) |=> irq);

   // R12
   irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !capture) |=> !irq);

   // R12
   irq_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_arm |=> !irq);

endmodule

// File: rtl/codec_test_path_ctl.sv
module codec_test_path_ctl
   import tmc_pkg::*;
#(
   parameter int          W         = 16,
   parameter int          ATT_SHIFT = 1,
   parameter int          IMP_W     = 5,
   parameter int unsigned LOOP_CODE = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             imp_wr,
   input  logic [IMP_W-1:0] imp_wdata,
   input  logic             rx_valid,
   input  logic [W-1:0]     rx_in,
   input  logic [W-1:0]     tone_in,
   output logic             rx_out_vld,
   output logic [W-1:0]     rx_out,
   output logic             bfilt_en,
   output logic             vout_en,
   input  logic             tx_valid,
   input  logic [W-1:0]     tx_raw,
   input  logic [W-1:0]     tx_hp,
   output logic             tx_out_vld,
   output logic [W-1:0]     tx_data,
   output logic             tx_oe,
   input  logic             host_rd,
   output logic [W-1:0]     host_rdata,
   output logic             irq
);

   test_cfg_t    cfg;
   logic         dig_loop_act;
   tx_src_e      tx_src;
   logic [W-1:0] rx_slot;
   logic         capture;

   tmc_mode_reg #(.IMP_W(IMP_W), .LOOP_CODE(LOOP_CODE)) u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr       (cfg_wr),
      .cfg_wdata    (cfg_wdata),
      .imp_wr       (imp_wr),
      .imp_wdata    (imp_wdata),
      .cfg          (cfg),
      .dig_loop_act (dig_loop_act),
      .tx_src       (tx_src),
      .vout_en      (vout_en),
      .bfilt_en     (bfilt_en)
   );

   tmc_rx_path #(.W(W), .ATT_SHIFT(ATT_SHIFT)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_in      (rx_in),
      .tone_in    (tone_in),
      .tone_on    (cfg.tone_on),
      .rx_cutoff  (cfg.rx_cutoff),
      .rx_atten   (cfg.rx_atten),
      .rx_out_vld (rx_out_vld),
      .rx_out     (rx_out),
      .rx_slot    (rx_slot)
   );

   tmc_tx_path #(.W(W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_valid   (tx_valid),
      .tx_raw     (tx_raw),
      .tx_hp      (tx_hp),
      .hp_bypass  (cfg.hp_bypass),
      .tx_src     (tx_src),
      .rx_out     (rx_out),
      .rx_slot    (rx_slot),
      .capture    (capture),
      .tx_out_vld (tx_out_vld),
      .tx_data    (tx_data),
      .tx_oe      (tx_oe)
   );

   tmc_host_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_arm (cfg.irq_arm),
      .capture (capture),
      .host_rd (host_rd),
      .irq     (irq)
   );

   assign host_rdata = tx_data;

   // R10
   dig_loop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_src == SRC_DIGLOOP) |=> (tx_data == $past(rx_out) && !vout_en));

   // R8
   iface_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_oe && cfg.iface_loop) |=> (tx_data == $past(rx_out)));

   // R7
   cutoff_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_oe && !irq) |=> !irq);

endmodule

// File: tb/test_codec_test_path_ctl.sv
module test_codec_test_path_ctl;

   localparam int B_TXCUT = 0, B_RXCUT = 1, B_HPBYP = 2, B_ATT = 3, B_ARM = 4,
                  B_IFACE = 5, B_DIG = 6, B_SLOT = 7, B_TONE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [8:0]  cfg_wdata = '0;
   logic        imp_wr = 1'b0;
   logic [4:0]  imp_wdata = '0;
   logic        rx_valid = 1'b0;
   logic [15:0] rx_in = '0, tone_in = '0;
   logic        rx_out_vld, bfilt_en, vout_en, tx_out_vld, tx_oe, irq;
   logic [15:0] rx_out, tx_data, host_rdata;
   logic        tx_valid = 1'b0;
   logic [15:0] tx_raw = '0, tx_hp = '0;
   logic        host_rd = 1'b0;

   always #5 clk = ~clk;

   codec_test_path_ctl i_codec_test_path_ctl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .imp_wr(imp_wr), .imp_wdata(imp_wdata), .rx_valid(rx_valid), .rx_in(rx_in),
      .tone_in(tone_in), .rx_out_vld(rx_out_vld), .rx_out(rx_out), .bfilt_en(bfilt_en),
      .vout_en(vout_en), .tx_valid(tx_valid), .tx_raw(tx_raw), .tx_hp(tx_hp),
      .tx_out_vld(tx_out_vld), .tx_data(tx_data), .tx_oe(tx_oe), .host_rd(host_rd),
      .host_rdata(host_rdata), .irq(irq)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [15:0] rxq[$];
   string       rxtag[$];
   logic [15:0] txq[$];
   string       txtag[$];

   logic [8:0]  m_cfg = '0;
   logic [4:0]  m_imp = '0;
   logic [15:0] last_rx_out = '0;
   logic [15:0] last_rx_raw = '0;
   logic [15:0] last_tx = '0;

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_cfg(logic [8:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
      m_cfg = v;
   endtask

   task automatic set_imp(logic [4:0] v);
      @(negedge clk);
      imp_wr = 1'b1; imp_wdata = v;
      @(negedge clk);
      imp_wr = 1'b0;
      m_imp = v;
   endtask

   function automatic logic [15:0] rx_model(logic [15:0] s, logic [15:0] t);
      logic signed [15:0] v;
      v = m_cfg[B_RXCUT] ? 16'sd0 : (m_cfg[B_TONE] ? signed'(t) : signed'(s));
      if (m_cfg[B_ATT]) v = v >>> 1;
      return unsigned'(v);
   endfunction

   task automatic send_rx(string req, logic [15:0] s, logic [15:0] t);
      logic [15:0] e;
      e = rx_model(s, t);
      @(negedge clk);
      rx_valid = 1'b1; rx_in = s; tone_in = t;
      rxq.push_back(e); rxtag.push_back(req);
      last_rx_out = e; last_rx_raw = s;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   function automatic bit dig_act();
      return (m_cfg[B_DIG] || m_imp == 5'b10000) && !m_cfg[B_RXCUT];
   endfunction

   task automatic drive_tx(string req, logic [15:0] raw, logic [15:0] hp, bit rd);
      logic [15:0] e;
      bit          has;
      has = !m_cfg[B_TXCUT];
      if (m_cfg[B_IFACE])     e = last_rx_out;
      else if (m_cfg[B_SLOT]) e = last_rx_raw;
      else if (dig_act())     e = last_rx_out;
      else                    e = m_cfg[B_HPBYP] ? raw : hp;
      @(negedge clk);
      tx_valid = 1'b1; tx_raw = raw; tx_hp = hp; host_rd = rd;
      if (has) begin
         txq.push_back(e); txtag.push_back(req); last_tx = e;
      end
      @(negedge clk);
      tx_valid = 1'b0; host_rd = 1'b0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && rx_out_vld) begin
         if (rxq.size() == 0) check("R2 unexpected rx strobe", 16'h1, 16'h0);
         else check(rxtag.pop_front(), rx_out, rxq.pop_front());
      end
      if (rst_n && tx_out_vld) begin
         if (txq.size() == 0) check("R7 unexpected tx strobe", 16'h1, 16'h0);
         else check(txtag.pop_front(), tx_data, txq.pop_front());
      end
   end

   task automatic finish_run();
      if (rxq.size() != 0 || txq.size() != 0)
         check("R2 missing strobes", 16'(rxq.size() + txq.size()), 16'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 rx_out", rx_out, 16'h0);
      check("R1 tx_data", tx_data, 16'h0);
      check("R1 irq", 16'(irq), 16'h0);
      check("R1 tx_oe", 16'(tx_oe), 16'h1);
      check("R1 vout_en", 16'(vout_en), 16'h1);
      check("R1 bfilt_en", 16'(bfilt_en), 16'h1);

      // R2
      send_rx("R2 pass", 16'h1234, 16'h7FFF);
      send_rx("R2 pass neg", 16'h8001, 16'h0000);
      // R3
      set_cfg(9'(1 << B_TONE));
      send_rx("R3 tone", 16'h1111, 16'h2222);
      // R5
      set_cfg(9'(1 << B_ATT));
      send_rx("R5 neg odd", 16'hFFFD, 16'h0);
      send_rx("R5 full scale", 16'h7FFF, 16'h0);
      set_cfg(9'((1 << B_ATT) | (1 << B_TONE)));
      send_rx("R5 tone atten", 16'h0001, 16'h8000);
      // R4
      set_cfg(9'((1 << B_RXCUT) | (1 << B_TONE)));
      check("R4 bfilt_en", 16'(bfilt_en), 16'h0);
      send_rx("R4 mute", 16'h5555, 16'h6666);

      // R6
      set_cfg(9'h0);
      send_rx("R2 setup", 16'h0AAA, 16'h0);
      drive_tx("R6 hp path", 16'h1000, 16'h2000, 1'b0);
      set_cfg(9'(1 << B_HPBYP));
      drive_tx("R6 bypass", 16'h1000, 16'h2000, 1'b0);

      // R9
      set_cfg(9'((1 << B_SLOT) | (1 << B_ATT)));
      send_rx("R5 setup", 16'h0ABC, 16'h0);
      drive_tx("R9 slot loop", 16'h3000, 16'h4000, 1'b0);
      // R8
      set_cfg(9'((1 << B_IFACE) | (1 << B_SLOT) | (1 << B_DIG)));
      drive_tx("R8 iface loop", 16'h3000, 16'h4000, 1'b0);
      // R10
      set_cfg(9'(1 << B_DIG));
      check("R10 vout_en off", 16'(vout_en), 16'h0);
      drive_tx("R10 dig loop", 16'h3000, 16'h4000, 1'b0);
      set_cfg(9'((1 << B_DIG) | (1 << B_SLOT)));
      drive_tx("R9 slot over dig", 16'h3000, 16'h4000, 1'b0);
      set_cfg(9'((1 << B_DIG) | (1 << B_RXCUT)));
      check("R10 cutoff restores vout", 16'(vout_en), 16'h1);
      drive_tx("R10 dig blocked", 16'h3000, 16'h4000, 1'b0);

      // R11
      set_cfg(9'h0);
      set_imp(5'b10000);
      check("R11 code vout", 16'(vout_en), 16'h0);
      drive_tx("R11 code loop", 16'h5000, 16'h6000, 1'b0);
      set_imp(5'b01000);
      check("R11 other code", 16'(vout_en), 16'h1);
      drive_tx("R11 other code path", 16'h5000, 16'h6000, 1'b0);

      // R7
      set_cfg(9'((1 << B_TXCUT) | (1 << B_IFACE) | (1 << B_SLOT) | (1 << B_DIG) | (1 << B_ARM)));
      check("R7 tx_oe", 16'(tx_oe), 16'h0);
      drive_tx("R7 cutoff", 16'h7000, 16'h7100, 1'b0);
      repeat (2) @(negedge clk);
      check("R7 data held", host_rdata, last_tx);
      check("R7 no irq", 16'(irq), 16'h0);

      // R12
      set_cfg(9'(1 << B_ARM));
      drive_tx("R12 capture", 16'h0123, 16'h0456, 1'b0);
      check("R12 irq set", 16'(irq), 16'h1);
      host_rd = 1'b1;
      #1 check("R12 host read", host_rdata, 16'h0456);
      @(negedge clk);
      host_rd = 1'b0;
      check("R12 irq cleared", 16'(irq), 16'h0);
      drive_tx("R12 capture 2", 16'h0, 16'h0789, 1'b0);
      drive_tx("R12 set beats clear", 16'h0, 16'h0ABC, 1'b1);
      check("R12 irq kept", 16'(irq), 16'h1);
      set_cfg(9'h0);
      drive_tx("R12 unarmed", 16'h0, 16'h0DEF, 1'b0);
      check("R12 unarmed irq", 16'(irq), 16'h0);

      repeat (3) @(negedge clk);
      done = 1;
      finish_run();
   end

endmodule